// File: doc/BRIEF.md
# Virtual Interrupt Event Aggregator

The aggregator gathers a set of single-bit event inputs and folds them into a small number of virtual interrupt lines. Each line owns 64 pending bits. A routing table decides which line and which bit each event lands on. The table is loaded through a configuration port. Each entry carries a valid flag and a flag that marks the source as level-type.

Software sees one register page per line on a plain read/write bus. Pages sit 0x1000 bytes apart. Inside a page, one address sets mask-enable bits when ones are written, and a second address clears them when ones are written. A 64-bit pending register is cleared by writing ones to it. A level-type source can also withdraw its own pending bit by pulsing its de-assert input. Each line drives one registered interrupt output toward the parent controller. That output is high while any bit is both pending and enabled.

Top module: `vint_aggregator`

## Requirements
- R1: After reset, every enable bit and pending bit reads 0, every interrupt output is low, and every routing entry is invalid.
- R2: The page of line n starts at byte address n*0x1000. The page offsets are 0x000 (enable set), 0x008 (enable clear) and 0x018 (pending). A write to any other offset, or to a page whose number is not below the line count, changes nothing. A read of such an address returns 0. Read data appears on `bus_rdata_o` in the cycle after the read strobe and reflects the registers as they stood before that clock edge.
- R3: Writing to offset 0x000 sets each enable bit whose write-data bit is 1 and leaves the others unchanged. Reading offset 0x000 or 0x008 returns the enable register.
- R4: Writing to offset 0x008 clears each enable bit whose write-data bit is 1 and leaves the others unchanged.
- R5: A pulse on `evt_set_i[e]` sets pending bit `map_bit` of line `map_line`, as held in entry e, one cycle after the pulse. Reading offset 0x018 returns all pending bits of the line. Two events may share one bit.
- R6: Writing ones to offset 0x018 clears those pending bits. Zero bits leave their pending bits unchanged.
- R7: For an entry whose level flag is 0 (edge-type), the pending bit stays set until software clears it. Pulses on `evt_clr_i[e]` have no effect.
- R8: For an entry whose level flag is 1, a pulse on `evt_clr_i[e]` clears its pending bit without any bus write.
- R9: An event whose routing entry is invalid, or whose entry names a line not below the line count, changes no pending bit.
- R10: `irq_o[n]` equals the OR of (pending AND enable) of line n as it stood one cycle earlier. A masked event still records its pending bit.
- R11: When a new event and a clearing action (a bus write-one-to-clear or a de-assert pulse) hit the same pending bit in the same cycle, the bit ends up set.
- R12: A routing-table write takes effect for events from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_set_i | input | N_EVENTS | One-cycle assert pulse per event source |
| evt_clr_i | input | N_EVENTS | One-cycle de-assert pulse per event source (level-type entries only) |
| map_we_i | input | 1 | Routing-table write strobe |
| map_evt_i | input | EVT_W | Event index of the entry to write |
| map_valid_i | input | 1 | Valid flag of the written entry |
| map_level_i | input | 1 | Level-type flag of the written entry |
| map_line_i | input | LINE_W | Target line of the written entry |
| map_bit_i | input | 6 | Target bit inside the line |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe |
| bus_addr_i | input | ADDR_W | Byte address |
| bus_wdata_i | input | 64 | Write data |
| bus_rdata_o | output | 64 | Registered read data |
| irq_o | output | N_LINES | Per-line interrupt toward the parent controller |

## Verification
The bench builds the block with 8 events, 3 lines and a 16-bit address. With 3 lines, page number 3 is still encodable by both the address and the 2-bit line field of the routing table, but it names no line. This makes the out-of-range page and the out-of-range routing target both reachable. With 8 events and random routing, events often collide on one bit. Events and clearing actions on the same bit often land in the same cycle. Edge and level entries share lines, so both clearing paths are exercised against each other.

// File: rtl/vint_agg_pkg.sv
package vint_agg_pkg;

    localparam int unsigned LINE_BITS  = 64;
    localparam int unsigned BIT_W      = 6;
    localparam int unsigned PAGE_SHIFT = 12;

    // page offsets: software depends on these
    localparam logic [PAGE_SHIFT-1:0] OFS_EN_SET = 12'h000;
    localparam logic [PAGE_SHIFT-1:0] OFS_EN_CLR = 12'h008;
    localparam logic [PAGE_SHIFT-1:0] OFS_PEND   = 12'h018;

    typedef logic [LINE_BITS-1:0] word_t;

    // per-line decoded bus command
    typedef struct packed {
        logic en_set;
        logic en_clr;
        logic pend_ack;
        logic rd_en;
        logic rd_pend;
    } page_cmd_t;

endpackage

// File: rtl/vint_agg_route.sv
module vint_agg_route
    import vint_agg_pkg::*;
#(
    parameter int N_EVENTS = 32,
    parameter int N_LINES  = 4,
    localparam int EVT_W   = (N_EVENTS > 1) ? $clog2(N_EVENTS) : 1,
    localparam int LINE_W  = (N_LINES > 1) ? $clog2(N_LINES) : 1,
    localparam int FLAT_W  = N_LINES * LINE_BITS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic [EVT_W-1:0]    cfg_evt,
    input  logic                cfg_valid,
    input  logic                cfg_level,
    input  logic [LINE_W-1:0]   cfg_line,
    input  logic [BIT_W-1:0]    cfg_bit,
    input  logic [N_EVENTS-1:0] evt_set,
    input  logic [N_EVENTS-1:0] evt_clr,
    output logic [FLAT_W-1:0]   hit_set,
    output logic [FLAT_W-1:0]   hit_clr
);

    typedef struct packed {
        logic              valid;
        logic              level;
        logic [LINE_W-1:0] line;
        logic [BIT_W-1:0]  bitpos;
    } route_ent_t;

    typedef struct packed {
        route_ent_t [N_EVENTS-1:0] tbl;
    } route_st_t;

    route_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cfg_we && (int'(cfg_evt) < N_EVENTS)) begin
            st_d.tbl[cfg_evt].valid  = cfg_valid;
            st_d.tbl[cfg_evt].level  = cfg_level;
            st_d.tbl[cfg_evt].line   = cfg_line;
            st_d.tbl[cfg_evt].bitpos = cfg_bit;
        end
    end

    // event steering uses the registered table only
    always_comb begin
        hit_set = '0;
        hit_clr = '0;
        for (int e = 0; e < N_EVENTS; e++) begin
            int idx;
            idx = int'(st_q.tbl[e].line) * LINE_BITS + int'(st_q.tbl[e].bitpos);
            if (st_q.tbl[e].valid && (int'(st_q.tbl[e].line) < N_LINES)) begin
                if (evt_set[e]) begin
                    hit_set[idx] = 1'b1;
                end
                if (evt_clr[e] && st_q.tbl[e].level) begin
                    hit_clr[idx] = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/vint_agg_decode.sv
module vint_agg_decode
    import vint_agg_pkg::*;
#(
    parameter int N_LINES  = 4,
    parameter int ADDR_W   = 16,
    localparam int PAGE_W  = ADDR_W - PAGE_SHIFT
) (
    input  logic                       bus_wr,
    input  logic                       bus_rd,
    input  logic [ADDR_W-1:0]          bus_addr,
    output page_cmd_t [N_LINES-1:0]    cmd
);

    logic [PAGE_W-1:0]     page;
    logic [PAGE_SHIFT-1:0] ofs;

    assign page = bus_addr[ADDR_W-1:PAGE_SHIFT];
    assign ofs  = bus_addr[PAGE_SHIFT-1:0];

    for (genvar l = 0; l < N_LINES; l++) begin : g_page
        logic sel;
        assign sel             = (page == PAGE_W'(l));
        assign cmd[l].en_set   = bus_wr && sel && (ofs == OFS_EN_SET);
        assign cmd[l].en_clr   = bus_wr && sel && (ofs == OFS_EN_CLR);
        assign cmd[l].pend_ack = bus_wr && sel && (ofs == OFS_PEND);
        assign cmd[l].rd_en    = bus_rd && sel && ((ofs == OFS_EN_SET) || (ofs == OFS_EN_CLR));
        assign cmd[l].rd_pend  = bus_rd && sel && (ofs == OFS_PEND);
    end

endmodule

// File: rtl/vint_agg_line.sv
module vint_agg_line
    import vint_agg_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  en_set,
    input  logic  en_clr,
    input  logic  pend_ack,
    input  word_t wdata,
    input  word_t hit_set,
    input  word_t hit_clr,
    output word_t en_o,
    output word_t pend_o,
    output logic  irq_o
);

    typedef struct packed {
        word_t en;
        word_t pend;
        logic  irq;
    } line_st_t;

    line_st_t st_d, st_q;

    always_comb begin
        word_t ack_mask;
        st_d     = st_q;
        ack_mask = pend_ack ? wdata : '0;
        if (en_set) begin
            st_d.en = st_d.en | wdata;
        end
        if (en_clr) begin
            st_d.en = st_d.en & ~wdata;
        end
        // a fresh event beats both clearing paths
        st_d.pend = ((st_q.pend & ~ack_mask) & ~hit_clr) | hit_set;
        st_d.irq  = |(st_q.pend & st_q.en);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign en_o   = st_q.en;
    assign pend_o = st_q.pend;
    assign irq_o  = st_q.irq;

endmodule

// File: rtl/vint_aggregator.sv
module vint_aggregator
    import vint_agg_pkg::*;
#(
    parameter int N_EVENTS = 32,
    parameter int N_LINES  = 4,
    parameter int ADDR_W   = 16,
    localparam int EVT_W   = (N_EVENTS > 1) ? $clog2(N_EVENTS) : 1,
    localparam int LINE_W  = (N_LINES > 1) ? $clog2(N_LINES) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N_EVENTS-1:0]  evt_set_i,
    input  logic [N_EVENTS-1:0]  evt_clr_i,
    input  logic                 map_we_i,
    input  logic [EVT_W-1:0]     map_evt_i,
    input  logic                 map_valid_i,
    input  logic                 map_level_i,
    input  logic [LINE_W-1:0]    map_line_i,
    input  logic [5:0]           map_bit_i,
    input  logic                 bus_wr_i,
    input  logic                 bus_rd_i,
    input  logic [ADDR_W-1:0]    bus_addr_i,
    input  logic [63:0]          bus_wdata_i,
    output logic [63:0]          bus_rdata_o,
    output logic [N_LINES-1:0]   irq_o
);

    localparam int FLAT_W = N_LINES * LINE_BITS;

    typedef struct packed {
        word_t rdata;
    } top_st_t;

    top_st_t st_d, st_q;

    logic [FLAT_W-1:0]       hit_set_flat;
    logic [FLAT_W-1:0]       hit_clr_flat;
    logic [FLAT_W-1:0]       en_flat;
    logic [FLAT_W-1:0]       st_flat;
    page_cmd_t [N_LINES-1:0] cmd;

    vint_agg_route #(
        .N_EVENTS (N_EVENTS),
        .N_LINES  (N_LINES)
    ) u_route (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (map_we_i),
        .cfg_evt   (map_evt_i),
        .cfg_valid (map_valid_i),
        .cfg_level (map_level_i),
        .cfg_line  (map_line_i),
        .cfg_bit   (map_bit_i),
        .evt_set   (evt_set_i),
        .evt_clr   (evt_clr_i),
        .hit_set   (hit_set_flat),
        .hit_clr   (hit_clr_flat)
    );

    vint_agg_decode #(
        .N_LINES (N_LINES),
        .ADDR_W  (ADDR_W)
    ) u_dec (
        .bus_wr   (bus_wr_i),
        .bus_rd   (bus_rd_i),
        .bus_addr (bus_addr_i),
        .cmd      (cmd)
    );

    for (genvar l = 0; l < N_LINES; l++) begin : g_line
        vint_agg_line u_line (
            .clk      (clk),
            .rst_n    (rst_n),
            .en_set   (cmd[l].en_set),
            .en_clr   (cmd[l].en_clr),
            .pend_ack (cmd[l].pend_ack),
            .wdata    (bus_wdata_i),
            .hit_set  (hit_set_flat[l*LINE_BITS +: LINE_BITS]),
            .hit_clr  (hit_clr_flat[l*LINE_BITS +: LINE_BITS]),
            .en_o     (en_flat[l*LINE_BITS +: LINE_BITS]),
            .pend_o   (st_flat[l*LINE_BITS +: LINE_BITS]),
            .irq_o    (irq_o[l])
        );
    end

    // read mux: at most one select is active
    always_comb begin
        st_d.rdata = '0;
        for (int l = 0; l < N_LINES; l++) begin
            if (cmd[l].rd_en) begin
                st_d.rdata = st_d.rdata | en_flat[l*LINE_BITS +: LINE_BITS];
            end
            if (cmd[l].rd_pend) begin
                st_d.rdata = st_d.rdata | st_flat[l*LINE_BITS +: LINE_BITS];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_rdata_o = st_q.rdata;

endmodule

// File: rtl/vint_agg_chk.sv
module vint_agg_chk #(
    parameter int N_LINES = 4,
    parameter int ADDR_W  = 16,
    localparam int FLAT_W = N_LINES * 64
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bus_wr_i,
    input logic [ADDR_W-1:0]  bus_addr_i,
    input logic [63:0]        bus_wdata_i,
    input logic [N_LINES-1:0] irq_o,
    input logic [FLAT_W-1:0]  en_flat,
    input logic [FLAT_W-1:0]  st_flat,
    input logic [FLAT_W-1:0]  set_flat
);

    a_r1_reset_irq_low: assert property (@(posedge clk)
        !rst_n |=> (irq_o == '0));

    a_r11_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((st_flat & $past(set_flat)) == $past(set_flat)));

    a_r5_no_spurious_pending: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((st_flat & ~$past(st_flat) & ~$past(set_flat)) == '0));

    for (genvar l = 0; l < N_LINES; l++) begin : g_chk
        a_r3_enable_set: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr_i && bus_addr_i == ADDR_W'(l * 4096))
            |=> ((en_flat[l*64 +: 64] & $past(bus_wdata_i)) == $past(bus_wdata_i)));

        a_r4_enable_clear: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr_i && bus_addr_i == ADDR_W'(l * 4096 + 8))
            |=> ((en_flat[l*64 +: 64] & $past(bus_wdata_i)) == '0));

        a_r6_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr_i && bus_addr_i == ADDR_W'(l * 4096 + 24))
            |=> ((st_flat[l*64 +: 64] & $past(bus_wdata_i) & ~$past(set_flat[l*64 +: 64])) == '0));

        a_r10_irq_tracks: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> (irq_o[l] == $past(|(st_flat[l*64 +: 64] & en_flat[l*64 +: 64]))));
    end

endmodule

bind vint_aggregator vint_agg_chk #(
    .N_LINES (N_LINES),
    .ADDR_W  (ADDR_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_wr_i    (bus_wr_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .irq_o       (irq_o),
    .en_flat     (en_flat),
    .st_flat     (st_flat),
    .set_flat    (hit_set_flat)
);

// File: tb/sim_vint_aggregator.sv
module sim_vint_aggregator;

    localparam int NE = 8;
    localparam int NL = 3;
    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NE-1:0] d_set = '0, d_clr = '0;
    logic          d_map_we = 1'b0, d_map_valid = 1'b0, d_map_level = 1'b0;
    logic [2:0]    d_map_evt = '0;
    logic [1:0]    d_map_line = '0;
    logic [5:0]    d_map_bit = '0;
    logic          d_wr = 1'b0, d_rd = 1'b0;
    logic [AW-1:0] d_addr = '0;
    logic [63:0]   d_wdata = '0;
    logic [63:0]   rdata;
    logic [NL-1:0] irq;

    int n_chk = 0;
    int n_err = 0;

    // reference model state
    logic [63:0] m_en [NL];
    logic [63:0] m_st [NL];
    logic        m_valid [NE];
    logic        m_level [NE];
    int          m_line [NE];
    int          m_bit [NE];

    always #2 clk = ~clk;

    vint_aggregator #(.N_EVENTS(NE), .N_LINES(NL), .ADDR_W(AW)) u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .evt_set_i   (d_set),
        .evt_clr_i   (d_clr),
        .map_we_i    (d_map_we),
        .map_evt_i   (d_map_evt),
        .map_valid_i (d_map_valid),
        .map_level_i (d_map_level),
        .map_line_i  (d_map_line),
        .map_bit_i   (d_map_bit),
        .bus_wr_i    (d_wr),
        .bus_rd_i    (d_rd),
        .bus_addr_i  (d_addr),
        .bus_wdata_i (d_wdata),
        .bus_rdata_o (rdata),
        .irq_o       (irq)
    );

    function automatic logic [AW-1:0] pa(input int line, input int ofs);
        return AW'(line * 4096 + ofs);
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] model_read(input logic [AW-1:0] a);
        int pg;
        int of;
        pg = int'(a[AW-1:12]);
        of = int'(a[11:0]);
        if (pg >= NL) return '0;
        if (of == 0 || of == 8) return m_en[pg];
        if (of == 24) return m_st[pg];
        return '0;
    endfunction

    // one clock: model update, edge, then port checks
    task automatic cyc(input string tag);
        logic [63:0] exp_rd;
        logic [NL-1:0] exp_irq;
        logic [63:0] sv [NL];
        logic [63:0] cv [NL];
        logic rd_now;
        for (int l = 0; l < NL; l++) begin
            exp_irq[l] = |(m_st[l] & m_en[l]);
            sv[l] = '0;
            cv[l] = '0;
        end
        rd_now = d_rd;
        exp_rd = model_read(d_addr);
        for (int e = 0; e < NE; e++) begin
            if (m_valid[e] && m_line[e] < NL) begin
                if (d_set[e]) sv[m_line[e]][m_bit[e]] = 1'b1;
                if (d_clr[e] && m_level[e]) cv[m_line[e]][m_bit[e]] = 1'b1;
            end
        end
        for (int l = 0; l < NL; l++) begin
            logic [63:0] ack;
            ack = (d_wr && d_addr == pa(l, 24)) ? d_wdata : '0;
            m_st[l] = (m_st[l] & ~ack & ~cv[l]) | sv[l];
            if (d_wr && d_addr == pa(l, 0)) m_en[l] = m_en[l] | d_wdata;
            if (d_wr && d_addr == pa(l, 8)) m_en[l] = m_en[l] & ~d_wdata;
        end
        if (d_map_we) begin
            m_valid[d_map_evt] = d_map_valid;
            m_level[d_map_evt] = d_map_level;
            m_line[d_map_evt]  = int'(d_map_line);
            m_bit[d_map_evt]   = int'(d_map_bit);
        end
        @(posedge clk);
        #1;
        chk("R10 irq", 64'(irq), 64'(exp_irq));
        if (rd_now) chk(tag, rdata, exp_rd);
        @(negedge clk);
        d_set = '0; d_clr = '0; d_map_we = 1'b0; d_wr = 1'b0; d_rd = 1'b0;
    endtask

    task automatic rd_chk(input logic [AW-1:0] a, input logic [63:0] exp, input string tag);
        d_rd = 1'b1; d_addr = a;
        cyc(tag);
        chk(tag, rdata, exp);
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [63:0] v, input string tag);
        d_wr = 1'b1; d_addr = a; d_wdata = v;
        cyc(tag);
    endtask

    task automatic map(input int e, input bit v, input bit lv, input int line, input int b);
        d_map_we = 1'b1; d_map_evt = 3'(e); d_map_valid = v; d_map_level = lv;
        d_map_line = 2'(line); d_map_bit = 6'(b);
        cyc("R12 map");
    endtask

    initial begin
        #(4 * 200000);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        for (int l = 0; l < NL; l++) begin m_en[l] = '0; m_st[l] = '0; end
        for (int e = 0; e < NE; e++) begin
            m_valid[e] = 1'b0; m_level[e] = 1'b0; m_line[e] = 0; m_bit[e] = 0;
        end
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        chk("R1 irq after reset", 64'(irq), 64'h0);
        for (int l = 0; l < NL; l++) begin
            rd_chk(pa(l, 0), 64'h0, "R1 enable reset");
            rd_chk(pa(l, 24), 64'h0, "R1 pending reset");
        end
        // unmapped event is dropped
        d_set = 8'hFF; cyc("R1 tbl");
        for (int l = 0; l < NL; l++) rd_chk(pa(l, 24), 64'h0, "R9 unmapped event");

        map(0, 1, 0, 1, 5);
        map(1, 1, 1, 1, 63);
        map(2, 1, 0, 2, 0);
        map(3, 0, 0, 0, 7);
        map(4, 1, 0, 0, 7);
        map(5, 1, 0, 3, 9);

        // R12: event in the same cycle as a table write uses the old entry
        d_map_we = 1'b1; d_map_evt = 3'd6; d_map_valid = 1'b1; d_map_level = 1'b0;
        d_map_line = 2'd2; d_map_bit = 6'd40; d_set = 8'h40;
        cyc("R12");
        rd_chk(pa(2, 24), 64'h0, "R12 old entry used");
        d_set = 8'h40; cyc("R12");
        rd_chk(pa(2, 24), 64'h1 << 40, "R12 new entry used");
        wr(pa(2, 24), 64'h1 << 40, "R6");

        d_set = 8'h01; cyc("R5");
        rd_chk(pa(1, 24), 64'h1 << 5, "R5 routed to line1 bit5");
        chk("R10 masked no irq", 64'(irq), 64'h0);
        wr(pa(1, 0), (64'h1 << 5) | (64'h1 << 63), "R3");
        cyc("R10");
        chk("R10 irq after unmask", 64'(irq[1]), 64'h1);
        rd_chk(pa(1, 8), (64'h1 << 5) | (64'h1 << 63), "R3 enable readback");
        wr(pa(1, 0), 64'h0, "R3 zero write");
        rd_chk(pa(1, 0), (64'h1 << 5) | (64'h1 << 63), "R3 zeros no effect");

        d_clr = 8'h01; cyc("R7");
        rd_chk(pa(1, 24), 64'h1 << 5, "R7 edge ignores deassert");
        d_set = 8'h02; cyc("R8");
        rd_chk(pa(1, 24), (64'h1 << 5) | (64'h1 << 63), "R8 level set");
        d_clr = 8'h02; cyc("R8");
        rd_chk(pa(1, 24), 64'h1 << 5, "R8 level deassert clears");
        d_set = 8'h02; cyc("R6");
        wr(pa(1, 24), 64'h1 << 5, "R6");
        rd_chk(pa(1, 24), 64'h1 << 63, "R6 ack clears only ones");

        // collisions
        d_set = 8'h01; d_wr = 1'b1; d_addr = pa(1, 24); d_wdata = 64'h1 << 5;
        cyc("R11");
        rd_chk(pa(1, 24), (64'h1 << 5) | (64'h1 << 63), "R11 event beats ack");
        d_set = 8'h02; d_clr = 8'h02; cyc("R11");
        rd_chk(pa(1, 24), (64'h1 << 5) | (64'h1 << 63), "R11 event beats deassert");

        wr(pa(1, 8), 64'h1 << 5, "R4");
        rd_chk(pa(1, 0), 64'h1 << 63, "R4 enable clear");

        d_set = 8'h08; cyc("R9");
        rd_chk(pa(0, 24), 64'h0, "R9 invalid entry dropped");
        d_set = 8'h20; cyc("R9");
        for (int l = 0; l < NL; l++) rd_chk(pa(l, 24), model_read(pa(l, 24)), "R9 out of range line");
        d_set = 8'h10; cyc("R5");
        rd_chk(pa(0, 24), 64'h1 << 7, "R5 line0 bit7");

        wr(pa(0, 16), 64'hFFFF_FFFF_FFFF_FFFF, "R2");
        wr(pa(3, 0), 64'hFFFF_FFFF_FFFF_FFFF, "R2");
        rd_chk(pa(0, 16), 64'h0, "R2 unused offset reads 0");
        rd_chk(pa(3, 24), 64'h0, "R2 missing page reads 0");
        rd_chk(pa(0, 0), 64'h0, "R2 stray writes ignored");

        // random phase
        for (int i = 0; i < 600; i++) begin
            if ($urandom % 3 == 0) d_set = NE'($urandom) & NE'($urandom);
            if ($urandom % 3 == 0) d_clr = NE'($urandom);
            if ($urandom % 3 == 0) begin
                int ofs_sel;
                ofs_sel = int'($urandom % 4);
                d_wr = 1'b1;
                d_addr = pa(int'($urandom % 4), (ofs_sel == 3) ? 16 : ofs_sel * 8 + ((ofs_sel == 2) ? 8 : 0));
                d_wdata = {$urandom, $urandom} & {$urandom, $urandom};
            end
            if ($urandom % 2 == 0) begin
                d_rd = 1'b1;
                d_addr = d_wr ? d_addr : pa(int'($urandom % 4), (($urandom % 2) == 0) ? 0 : 24);
            end
            if ($urandom % 20 == 0) begin
                d_map_we = 1'b1; d_map_evt = 3'($urandom); d_map_valid = ($urandom % 4) != 0;
                d_map_level = 1'($urandom); d_map_line = 2'($urandom); d_map_bit = 6'($urandom);
            end
            cyc("R5 random read");
        end

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule